// File: doc/BRIEF.md
# Direct-connect interrupt router

This block takes a bank of input pins and sends chosen ones straight to a small set of dedicated interrupt lines. These lines skip the per-pin status and summary interrupt path. Each line has a routing register, written over a simple register bus. The register names the source pin and a polarity. The line then follows that pin's synchronised level, inverted or not by the polarity. It does so only while the source pin has its direct-connect enable set.

The per-pin interrupt configuration that holds that enable lives in the same block. It also holds the normal interrupt enable and the raw-status enable, which go out to the pin detection logic. Hardware keeps the two kinds of routing from being on at the same time. Setting a pin's normal interrupt enable clears its direct-connect enable. Setting direct connect clears its normal and raw-status enables.

The receiving interrupt controller only accepts high-level or rising conditions. Software should therefore program polarity 1 for any line it relies on. Polarity 0 is implemented but is of no use to that receiver.

Top module: `dc_irq_router`

## Requirements
- R1: After reset every line in `dc_irq_o` is low and every register reads zero, including the `intr_en_o`, `raw_en_o` and `dc_en_o` vectors.
- R2: Routing register `l` sits at byte address 0x2800 + 4*l. Bits [7:0] hold the source pin index and bit 8 holds the polarity (1 = active high). It reads back in those positions, and all other read bits are zero.
- R3: Pin configuration register `p` sits at byte address 0x1008 + 0x10*p. Bit 0 is the normal interrupt enable, bit 4 the raw-status enable and bit 8 the direct-connect enable. They read back in those positions and drive `intr_en_o[p]`, `raw_en_o[p]` and `dc_en_o[p]`.
- R4: For a routed pin with direct connect enabled, the line equals the synchronised pin level when the polarity is 1, and its inverse when the polarity is 0.
- R5: A line is low whenever its selected pin has direct connect disabled.
- R6: A pin index of `NUM_PINS` or higher drives the line low, whatever the polarity.
- R7: A change at a pin input shows on a routed line at the third rising clock edge after the input is set up: two synchroniser stages, then the output register.
- R8: A configuration write with bit 8 set and bit 0 clear stores direct connect on, and clears both the normal and raw-status enables, whatever bit 4 holds.
- R9: A configuration write with bit 0 set stores direct connect off, whatever bit 8 holds.
- R10: A register write at a rising edge affects the lines from the next rising edge on.
- R11: Writes to addresses outside both register ranges change nothing, and such addresses read zero.
- R12: Several lines may select the same pin, and each applies its own polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address for writes and reads |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| intr_en_o | output | NUM_PINS | Per-pin normal interrupt enable |
| raw_en_o | output | NUM_PINS | Per-pin raw-status enable |
| dc_en_o | output | NUM_PINS | Per-pin direct-connect enable |
| dc_irq_o | output | NUM_LINES | Direct interrupt lines |

## Verification
Faults in the synchroniser, the output register or the index compare show at the ports within three clocks of a pin change. They appear as a line that leads, lags or follows the wrong pin. Faults in a routing or pin configuration register show on the very next read, and on the lines one clock after the write. A lost enable-exclusion rule shows at once as both `intr_en_o` and `dc_en_o` high for the same pin. The bench predicts every output on every clock from its own model, so any of these appears as a miscompare in the cycle it first happens.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int IDX_W      = 8;
  localparam int POL_BIT    = 8;
  localparam int EN_BIT     = 0;
  localparam int RAW_BIT    = 4;
  localparam int DC_BIT     = 8;
  localparam int ROUTE_BASE = 'h2800;
  localparam int ROUTE_STEP = 4;
  localparam int CFG_BASE   = 'h1008;
  localparam int CFG_STEP   = 'h10;

  typedef struct packed {
    logic             pol;
    logic [IDX_W-1:0] idx;
  } route_t;
endpackage

// File: rtl/dcr_sync.sv
module dcr_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcr_pin_cfg.sv
module dcr_pin_cfg
  import dcr_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_PINS-1:0] intr_en_o,
  output logic [NUM_PINS-1:0] raw_en_o,
  output logic [NUM_PINS-1:0] dc_en_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(CFG_BASE + CFG_STEP * p);
    logic wr;
    assign wr = we_i && (addr_i == ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        intr_en_o[p] <= 1'b0;
        raw_en_o[p]  <= 1'b0;
        dc_en_o[p]   <= 1'b0;
      end else if (wr) begin
        // normal enable wins; direct connect clears the normal path
        intr_en_o[p] <= wdata_i[EN_BIT];
        dc_en_o[p]   <= wdata_i[DC_BIT] & ~wdata_i[EN_BIT];
        raw_en_o[p]  <= wdata_i[RAW_BIT] & ~(wdata_i[DC_BIT] & ~wdata_i[EN_BIT]);
      end
    end

    a_r9_enable_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && wdata_i[EN_BIT]) |=> !dc_en_o[p]);
    a_r8_dc_clears_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && !wdata_i[EN_BIT] && wdata_i[DC_BIT]) |=> (dc_en_o[p] && !intr_en_o[p] && !raw_en_o[p]));
    a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dc_en_o[p] && (intr_en_o[p] || raw_en_o[p])));
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr_i == ADDR_W'(CFG_BASE + CFG_STEP * p)) begin
        rdata_o[EN_BIT]  = intr_en_o[p];
        rdata_o[RAW_BIT] = raw_en_o[p];
        rdata_o[DC_BIT]  = dc_en_o[p];
      end
    end
  end
endmodule

// File: rtl/dcr_route_regs.sv
module dcr_route_regs
  import dcr_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 14
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  output route_t [NUM_LINES-1:0]       route_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(ROUTE_BASE + ROUTE_STEP * l);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          route_o[l] <= '0;
      else if (we_i && (addr_i == ADDR)) begin
        route_o[l].idx <= wdata_i[IDX_W-1:0];
        route_o[l].pol <= wdata_i[POL_BIT];
      end
    end

    a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR) |=> (route_o[l].idx == $past(wdata_i[IDX_W-1:0])));
  end

  always_comb begin
    rdata_o = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (addr_i == ADDR_W'(ROUTE_BASE + ROUTE_STEP * l)) begin
        rdata_o[IDX_W-1:0] = route_o[l].idx;
        rdata_o[POL_BIT]   = route_o[l].pol;
      end
    end
  end
endmodule

// File: rtl/dcr_line.sv
module dcr_line
  import dcr_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  route_t              route_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] dc_en_i,
  output logic                line_o
);
  logic sel_lvl, sel_en, line_d;

  always_comb begin
    sel_lvl = 1'b0;
    sel_en  = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (route_i.idx == IDX_W'(p)) begin
        sel_lvl = lvl_i[p];
        sel_en  = dc_en_i[p];
      end
    end
    line_d = sel_en & (sel_lvl ~^ route_i.pol);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_o <= 1'b0;
    else         line_o <= line_d;
  end

  a_r6_out_of_range_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(route_i.idx) >= NUM_PINS) |=> !line_o);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    a_r5_gated_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (route_i.idx == IDX_W'(p) && !dc_en_i[p]) |=> !line_o);
    a_r4_high_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (route_i.idx == IDX_W'(p) && dc_en_i[p] && route_i.pol) |=> (line_o == $past(lvl_i[p])));
  end
endmodule

// File: rtl/dc_irq_router.sv
module dc_irq_router
  import dcr_pkg::*;
#(
  parameter int NUM_PINS  = 16,
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PINS-1:0]  pin_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic [NUM_PINS-1:0]  intr_en_o,
  output logic [NUM_PINS-1:0]  raw_en_o,
  output logic [NUM_PINS-1:0]  dc_en_o,
  output logic [NUM_LINES-1:0] dc_irq_o
);
  localparam int SYNC_STAGES = 2;

  logic [NUM_PINS-1:0]    pin_sync;
  logic [31:0]            cfg_rdata, route_rdata;
  route_t [NUM_LINES-1:0] route;

  dcr_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync)
  );

  dcr_pin_cfg #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(cfg_rdata), .intr_en_o, .raw_en_o, .dc_en_o
  );

  dcr_route_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_route (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(route_rdata), .route_o(route)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    dcr_line #(.NUM_PINS(NUM_PINS)) u_line (
      .clk_i, .rst_ni, .route_i(route[l]), .lvl_i(pin_sync),
      .dc_en_i(dc_en_o), .line_o(dc_irq_o[l])
    );
  end

  // address ranges are disjoint, so OR is a mux
  assign reg_rdata_o = cfg_rdata | route_rdata;
endmodule

// File: tb/dc_irq_router_test.sv
module dc_irq_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NL = 8;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] intr_en, raw_en, dc_en;
  logic [NL-1:0] irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string req  = "R1";

  // reference model state
  int unsigned m_idx [NL];
  bit          m_pol [NL];
  bit [NP-1:0] m_en, m_raw, m_dc, m_s1, m_s2;
  bit [NL-1:0] m_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_irq_router #(.NUM_PINS(NP), .NUM_LINES(NL), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .intr_en_o(intr_en), .raw_en_o(raw_en),
    .dc_en_o(dc_en), .dc_irq_o(irq)
  );

  function automatic bit [31:0] m_read(input int unsigned a);
    bit [31:0] r = '0;
    for (int l = 0; l < NL; l++)
      if (a == 'h2800 + 4*l) r = {23'd0, m_pol[l], 8'(m_idx[l])};
    for (int p = 0; p < NP; p++)
      if (a == 'h1008 + 'h10*p) begin
        r[0] = m_en[p]; r[4] = m_raw[p]; r[8] = m_dc[p];
      end
    return r;
  endfunction

  function automatic void m_reset();
    for (int l = 0; l < NL; l++) begin m_idx[l] = 0; m_pol[l] = 0; end
    m_en = '0; m_raw = '0; m_dc = '0; m_s1 = '0; m_s2 = '0; m_out = '0;
  endfunction

  // one clock edge of the model, using the inputs held across it
  function automatic void m_step();
    bit [NL-1:0] nxt = '0;
    for (int l = 0; l < NL; l++)
      if (m_idx[l] < NP && m_dc[m_idx[l]])
        nxt[l] = m_pol[l] ? m_s2[m_idx[l]] : !m_s2[m_idx[l]];
    m_s2 = m_s1;
    m_s1 = pins;
    if (we) begin
      for (int l = 0; l < NL; l++)
        if (32'(addr) == 'h2800 + 4*l) begin m_idx[l] = wdata[7:0]; m_pol[l] = wdata[8]; end
      for (int p = 0; p < NP; p++)
        if (32'(addr) == 'h1008 + 'h10*p) begin
          if (wdata[0])      begin m_en[p] = 1; m_raw[p] = wdata[4]; m_dc[p] = 0; end
          else if (wdata[8]) begin m_en[p] = 0; m_raw[p] = 0;        m_dc[p] = 1; end
          else               begin m_en[p] = 0; m_raw[p] = wdata[4]; m_dc[p] = 0; end
        end
    end
    m_out = nxt;
  endfunction

  task automatic compare();
    vectors++;
    if (irq !== m_out || intr_en !== m_en || raw_en !== m_raw || dc_en !== m_dc) begin
      errors++;
      $display("FAIL %s: irq=%h en=%h raw=%h dc=%h expected irq=%h en=%h raw=%h dc=%h",
               req, irq, intr_en, raw_en, dc_en, m_out, m_en, m_raw, m_dc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    m_step();
    compare();
  endtask

  task automatic wr(input int unsigned a, input bit [31:0] d);
    we = 1'b1; addr = AW'(a); wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd_check(input int unsigned a, input bit [31:0] exp, input string r);
    addr = AW'(a);
    #1;
    vectors++;
    if (rdata !== exp || rdata !== m_read(a)) begin
      errors++;
      $display("FAIL %s: read %h = %h expected %h", r, a, rdata, exp);
    end
  endtask

  task automatic line_check(input int l, input bit exp, input string r);
    vectors++;
    if (irq[l] !== exp) begin
      errors++;
      $display("FAIL %s: line %0d = %b expected %b", r, l, irq[l], exp);
    end
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      pins = NP'($urandom());
      tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    req = "R1";
    tick();
    rd_check('h2800, 32'h0, "R1");
    rd_check('h1008, 32'h0, "R1");
    line_check(0, 1'b0, "R1");

    // R2: routing register layout and readback
    req = "R2";
    wr('h2800, 32'hFFFF_F305);
    rd_check('h2800, 32'h0000_0105, "R2");
    wr('h2800, 32'h0000_0103);
    rd_check('h2800, 32'h0000_0103, "R2");

    // R3: pin config layout, direct connect on pin 3
    req = "R3";
    wr('h1008 + 'h10*3, 32'h0000_0100);
    rd_check('h1008 + 'h10*3, 32'h0000_0100, "R3");
    wr('h1008 + 'h10*2, 32'h0000_0011);
    rd_check('h1008 + 'h10*2, 32'h0000_0011, "R3");
    tick();

    // R7: three-edge latency from pin to line
    req = "R7";
    pins[3] = 1'b1;
    tick(); line_check(0, 1'b0, "R7");
    tick(); line_check(0, 1'b0, "R7");
    tick(); line_check(0, 1'b1, "R7");
    pins[3] = 1'b0;
    tick(); tick(); line_check(0, 1'b1, "R7");
    tick(); line_check(0, 1'b0, "R7");

    // R4: both polarities on pin 3
    req = "R4";
    wr('h2804, 32'h0000_0003);
    run_random(60);

    // R10: change takes effect the next edge
    req = "R10";
    pins = '0;
    repeat (3) tick();
    wr('h2804, 32'h0000_0103);
    line_check(1, 1'b1, "R10");
    tick();
    line_check(1, 1'b0, "R10");

    // R5: disable direct connect on pin 3
    req = "R5";
    wr('h2804, 32'h0000_0003);
    wr('h1008 + 'h10*3, 32'h0000_0000);
    run_random(20);
    line_check(0, 1'b0, "R5");
    line_check(1, 1'b0, "R5");

    // R8: direct connect clears normal and raw enables
    req = "R8";
    wr('h1008 + 'h10*5, 32'h0000_0011);
    wr('h1008 + 'h10*5, 32'h0000_0110);
    rd_check('h1008 + 'h10*5, 32'h0000_0100, "R8");

    // R9: normal enable wins over direct connect
    req = "R9";
    wr('h1008 + 'h10*6, 32'h0000_0111);
    rd_check('h1008 + 'h10*6, 32'h0000_0011, "R9");
    wr('h1008 + 'h10*6, 32'h0000_0100);
    wr('h1008 + 'h10*6, 32'h0000_0001);
    rd_check('h1008 + 'h10*6, 32'h0000_0001, "R9");

    // R6: out-of-range index, low polarity would otherwise drive high
    req = "R6";
    wr('h2808, 32'h0000_00C8);
    wr('h280C, 32'h0000_0010);
    pins = '0;
    repeat (4) tick();
    line_check(2, 1'b0, "R6");
    line_check(3, 1'b0, "R6");
    run_random(10);

    // R11: unmapped writes ignored, unmapped reads zero
    req = "R11";
    wr('h2800 + 4*NL, 32'h0000_0105);
    wr('h1009, 32'h0000_0001);
    wr('h1008 + 'h10*NP, 32'h0000_0100);
    rd_check('h2800 + 4*NL, 32'h0, "R11");
    rd_check('h1009, 32'h0, "R11");
    rd_check('h1008 + 'h10*NP, 32'h0, "R11");
    rd_check('h1008 + 'h10*5, 32'h0000_0100, "R11");
    tick();

    // R12: several lines on pin 5, mixed polarity
    req = "R12";
    for (int l = 3; l < NL; l++) wr('h2800 + 4*l, {23'd0, 1'(l % 2), 8'd5});
    pins = '0; pins[5] = 1'b1;
    repeat (3) tick();
    line_check(3, 1'b1, "R12");
    line_check(4, 1'b0, "R12");
    run_random(60);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule